// File: doc/BRIEF.md
# Effective Address Generator

This unit sits between the decode stage and the load-store port of a 32-bit single-address processor. From an addressing-mode code, an access size, four register values (the named pointer register, the index register R0, the global base register and the program counter) and a raw displacement field, it forms the memory address for the access. It also forms the pointer value to be written back for the auto-increment and auto-decrement modes. For the PC-relative branch forms, it produces the branch target instead.

All results are computed in one combinational pass and captured in a single output register, so every result appears exactly one clock after its request. A misalignment flag marks word accesses at odd addresses and longword accesses off a 4-byte boundary. Raising the exception is left to the stage that consumes the flag.

Top module: `eff_addr_gen`

## Requirements
- R1: A request sampled with `in_vld` high gives `out_vld` high with its results on the next clock. A cycle without `in_vld` gives `out_vld` low on the next clock. After reset all outputs are zero.
- R2: Mode 0 (pointer indirect) gives `out_ea` = `rn_val`. Reserved modes 10 to 15 behave like mode 0.
- R3: Mode 1 (post-increment) gives `out_ea` = `rn_val` and `out_wb_val` = `rn_val` + step. The step is 1, 2 or 4 for `size` 0 (byte), 1 (word) and 2 (longword); `size` 3 acts as longword.
- R4: Mode 2 (pre-decrement) gives `out_ea` = `out_wb_val` = `rn_val` − step.
- R5: Mode 3 gives `out_ea` = `rn_val` + `disp[3:0]` × step. `disp[3:0]` is unsigned, and `disp[11:4]` has no effect.
- R6: Mode 4 gives `out_ea` = `rn_val` + `r0_val`. Mode 6 gives `out_ea` = `gbr_val` + `r0_val`. Both sums wrap modulo 2^32.
- R7: Mode 5 gives `out_ea` = `gbr_val` + `disp[7:0]` × step, with `disp[7:0]` unsigned.
- R8: Mode 7 (PC literal) gives `pc_val` + `disp[7:0]` × step. For a longword it gives (`pc_val` with bits 1:0 cleared) + `disp[7:0]` × 4.
- R9: Mode 8 gives `pc_val` + sign-extended `disp[7:0]` × 2. Mode 9 gives `pc_val` + sign-extended `disp[11:0]` × 2. Both raise `out_branch`.
- R10: `out_misalign` is high when `out_ea[0]` is set for a word access or a branch, or when `out_ea[1:0]` is nonzero for a longword. It is never high for a byte access.
- R11: `out_wb_en` is high only for modes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Request strobe |
| mode | input | 4 | Addressing-mode code |
| size | input | 2 | Access size code |
| rn_val | input | 32 | Pointer register value |
| r0_val | input | 32 | Index register value |
| gbr_val | input | 32 | Global base register value |
| pc_val | input | 32 | Program counter value |
| disp | input | 12 | Raw displacement field |
| out_vld | output | 1 | Result valid |
| out_ea | output | 32 | Effective address or branch target |
| out_wb_en | output | 1 | Pointer write-back enable |
| out_wb_val | output | 32 | Pointer write-back value |
| out_misalign | output | 1 | Alignment violation flag |
| out_branch | output | 1 | Result is a branch target |

## Verification
The assertions run on every cycle. They check the one-cycle valid timing, pointer indirect addressing, the post-increment write-back arithmetic, the confinement of write-back to the two pointer-update modes, and the relation between the misalignment flag and the low address bits.

Only the directed scenarios can show the numeric results of the scaled, indexed and base-relative modes. The same holds for the longword PC mask, for sign extension at the edges of the 8-bit and 12-bit branch ranges, for index wrap-around, and for the fact that the unused displacement bits have no effect.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [3:0] {
        AM_PTR      = 4'd0,
        AM_POSTINC  = 4'd1,
        AM_PREDEC   = 4'd2,
        AM_PTR_D4   = 4'd3,
        AM_PTR_IDX  = 4'd4,
        AM_GB_D8    = 4'd5,
        AM_GB_IDX   = 4'd6,
        AM_PC_LIT   = 4'd7,
        AM_BR_S8    = 4'd8,
        AM_BR_S12   = 4'd9
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } asize_e;

    // log2 of the access width in bytes; the reserved code counts as longword
    function automatic logic [1:0] size_log2(input asize_e s);
        case (s)
            SZ_BYTE: size_log2 = 2'd0;
            SZ_WORD: size_log2 = 2'd1;
            default: size_log2 = 2'd2;
        endcase
    endfunction

    // Reserved codes fold onto pointer indirect
    function automatic amode_e fold_mode(input logic [3:0] m);
        if (m > 4'd9) fold_mode = AM_PTR;
        else          fold_mode = amode_e'(m);
    endfunction

    function automatic logic is_branch(input amode_e m);
        is_branch = (m == AM_BR_S8) || (m == AM_BR_S12);
    endfunction

endpackage

// File: rtl/eag_offset.sv
module eag_offset
    import eag_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int D4W  = 4,
    parameter int D8W  = 8,
    parameter int D12W = 12
) (
    input  amode_e            mode_i,
    input  logic [1:0]        lg_i,
    input  logic [XLEN-1:0]   r0_i,
    input  logic [D12W-1:0]   disp_i,
    output logic [XLEN-1:0]   offset_o,
    output logic [XLEN-1:0]   step_o
);
    logic [XLEN-1:0] u4, u8, s8, s12;

    always_comb begin
        u4  = {{(XLEN-D4W){1'b0}}, disp_i[D4W-1:0]};
        u8  = {{(XLEN-D8W){1'b0}}, disp_i[D8W-1:0]};
        s8  = {{(XLEN-D8W){disp_i[D8W-1]}}, disp_i[D8W-1:0]};
        s12 = {{(XLEN-D12W){disp_i[D12W-1]}}, disp_i[D12W-1:0]};
        step_o = {{(XLEN-1){1'b0}}, 1'b1} << lg_i;
        case (mode_i)
            AM_PREDEC:             offset_o = '0 - step_o;
            AM_PTR_D4:             offset_o = u4 << lg_i;
            AM_PTR_IDX, AM_GB_IDX: offset_o = r0_i;
            AM_GB_D8, AM_PC_LIT:   offset_o = u8 << lg_i;
            AM_BR_S8:              offset_o = s8 << 1;
            AM_BR_S12:             offset_o = s12 << 1;
            default:               offset_o = '0;
        endcase
    end
endmodule

// File: rtl/eag_base.sv
module eag_base
    import eag_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  amode_e          mode_i,
    input  logic [1:0]      lg_i,
    input  logic [XLEN-1:0] rn_i,
    input  logic [XLEN-1:0] gbr_i,
    input  logic [XLEN-1:0] pc_i,
    output logic [XLEN-1:0] base_o
);
    always_comb begin
        case (mode_i)
            AM_GB_D8, AM_GB_IDX: base_o = gbr_i;
            AM_PC_LIT:           base_o = (lg_i == 2'd2) ? {pc_i[XLEN-1:2], 2'b00} : pc_i;
            AM_BR_S8, AM_BR_S12: base_o = pc_i;
            default:             base_o = rn_i;
        endcase
    end
endmodule

// File: rtl/eag_align.sv
module eag_align #(
    parameter int XLEN   = 32,
    parameter int NSIZES = 3
) (
    input  logic [XLEN-1:0] ea_i,
    input  logic [1:0]      lg_i,
    output logic            mis_o
);
    logic [NSIZES-1:0] bad;

    for (genvar g = 0; g < NSIZES; g++) begin : g_chk
        if (g == 0) begin : g_byte
            assign bad[g] = 1'b0;
        end else begin : g_wide
            assign bad[g] = |ea_i[g-1:0];
        end
    end

    assign mis_o = (int'(lg_i) < NSIZES) ? bad[lg_i] : 1'b0;
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int MW   = 4,
    parameter int SW   = 2,
    parameter int D4W  = 4,
    parameter int D8W  = 8,
    parameter int D12W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [MW-1:0]    mode,
    input  logic [SW-1:0]    size,
    input  logic [XLEN-1:0]  rn_val,
    input  logic [XLEN-1:0]  r0_val,
    input  logic [XLEN-1:0]  gbr_val,
    input  logic [XLEN-1:0]  pc_val,
    input  logic [D12W-1:0]  disp,
    output logic             out_vld,
    output logic [XLEN-1:0]  out_ea,
    output logic             out_wb_en,
    output logic [XLEN-1:0]  out_wb_val,
    output logic             out_misalign,
    output logic             out_branch
);
    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] ea;
        logic            wb_en;
        logic [XLEN-1:0] wb_val;
        logic            mis;
        logic            br;
    } res_t;

    res_t res_d, res_q;

    amode_e          am;
    logic [1:0]      lg_data, lg_chk;
    logic [XLEN-1:0] base, offset, step, sum;
    logic            mis;

    assign am      = fold_mode(mode);
    assign lg_data = size_log2(asize_e'(size));
    assign lg_chk  = is_branch(am) ? 2'd1 : lg_data;
    assign sum     = base + offset;

    eag_base #(.XLEN(XLEN)) u_base (
        .mode_i (am),
        .lg_i   (lg_data),
        .rn_i   (rn_val),
        .gbr_i  (gbr_val),
        .pc_i   (pc_val),
        .base_o (base)
    );

    eag_offset #(.XLEN(XLEN), .D4W(D4W), .D8W(D8W), .D12W(D12W)) u_off (
        .mode_i   (am),
        .lg_i     (lg_data),
        .r0_i     (r0_val),
        .disp_i   (disp),
        .offset_o (offset),
        .step_o   (step)
    );

    eag_align #(.XLEN(XLEN), .NSIZES(3)) u_align (
        .ea_i  (sum),
        .lg_i  (lg_chk),
        .mis_o (mis)
    );

    always_comb begin
        res_d = '0;
        if (in_vld) begin
            res_d.vld    = 1'b1;
            res_d.ea     = sum;
            res_d.wb_en  = (am == AM_POSTINC) || (am == AM_PREDEC);
            res_d.wb_val = res_d.wb_en ? ((am == AM_POSTINC) ? sum + step : sum) : '0;
            res_d.mis    = mis;
            res_d.br     = is_branch(am);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_vld      = res_q.vld;
    assign out_ea       = res_q.ea;
    assign out_wb_en    = res_q.wb_en;
    assign out_wb_val   = res_q.wb_val;
    assign out_misalign = res_q.mis;
    assign out_branch   = res_q.br;
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld,
    input logic [3:0]      mode,
    input logic [1:0]      size,
    input logic [XLEN-1:0] rn_val,
    input logic            out_vld,
    input logic [XLEN-1:0] out_ea,
    input logic            out_wb_en,
    input logic [XLEN-1:0] out_wb_val,
    input logic            out_misalign,
    input logic            out_branch
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    a_r2_ptr_indirect: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 4'd0) |=> (out_ea == $past(rn_val)));

    a_r3_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode == 4'd1) |=>
        (out_wb_en && out_ea == $past(rn_val) &&
         out_wb_val == $past(rn_val) + ((size == 2'd0) ? 32'd1 : 32'd0) * 0 +
         (($past(size) == 2'd0) ? 32'd1 : ($past(size) == 2'd1) ? 32'd2 : 32'd4)));

    a_r11_wb_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && mode != 4'd1 && mode != 4'd2) |=> !out_wb_en);

    a_r9_branch_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        out_branch |-> (out_vld && !out_wb_en));

    a_r10_byte_never: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && size == 2'd0 && mode != 4'd8 && mode != 4'd9) |=> !out_misalign);

    a_r10_long_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && size[1] && mode != 4'd8 && mode != 4'd9) |=>
        (out_misalign == (out_ea[1:0] != 2'b00)));
endmodule

bind eff_addr_gen eag_checker #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_vld       (in_vld),
    .mode         (mode),
    .size         (size),
    .rn_val       (rn_val),
    .out_vld      (out_vld),
    .out_ea       (out_ea),
    .out_wb_en    (out_wb_en),
    .out_wb_val   (out_wb_val),
    .out_misalign (out_misalign),
    .out_branch   (out_branch)
);

// File: tb/sim_eff_addr_gen.sv
module sim_eff_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [31:0] rn_val = '0, r0_val = '0, gbr_val = '0, pc_val = '0;
    logic [11:0] disp = '0;
    logic        out_vld, out_wb_en, out_misalign, out_branch;
    logic [31:0] out_ea, out_wb_val;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    eff_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode), .size(size),
        .rn_val(rn_val), .r0_val(r0_val), .gbr_val(gbr_val), .pc_val(pc_val),
        .disp(disp), .out_vld(out_vld), .out_ea(out_ea), .out_wb_en(out_wb_en),
        .out_wb_val(out_wb_val), .out_misalign(out_misalign), .out_branch(out_branch)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive one request at a falling edge; results are registered at the next rising edge
    task automatic issue(input logic [3:0] m, input logic [1:0] s, input logic [31:0] rn,
                         input logic [31:0] r0, input logic [31:0] gb, input logic [31:0] pc,
                         input logic [11:0] d);
        @(negedge clk);
        in_vld = 1'b1; mode = m; size = s; rn_val = rn; r0_val = r0;
        gbr_val = gb; pc_val = pc; disp = d;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "vld after reset", {31'b0, out_vld}, 32'd0);
        chk("R1", "ea after reset", out_ea, 32'd0);
        chk("R1", "wb after reset", {31'b0, out_wb_en}, 32'd0);
    endtask

    task automatic t_ptr;
        issue(4'd0, 2'd2, 32'h1000_0040, 32'h5, 32'h0, 32'h0, 12'hFFF);
        chk("R1", "vld one cycle later", {31'b0, out_vld}, 32'd1);
        chk("R2", "ptr ea", out_ea, 32'h1000_0040);
        chk("R11", "ptr no wb", {31'b0, out_wb_en}, 32'd0);
        issue(4'd13, 2'd0, 32'h0000_7777, 32'h5, 32'h100, 32'h200, 12'h3);
        chk("R2", "reserved mode ea", out_ea, 32'h0000_7777);
    endtask

    task automatic t_postinc;
        issue(4'd1, 2'd2, 32'h2000, 32'h0, 32'h0, 32'h0, 12'h0);
        chk("R3", "post long ea", out_ea, 32'h2000);
        chk("R3", "post long wb", out_wb_val, 32'h2004);
        chk("R11", "post wb_en", {31'b0, out_wb_en}, 32'd1);
        issue(4'd1, 2'd0, 32'h2000, 32'h0, 32'h0, 32'h0, 12'h0);
        chk("R3", "post byte wb", out_wb_val, 32'h2001);
        issue(4'd1, 2'd3, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0, 12'h0);
        chk("R3", "post size3 wrap wb", out_wb_val, 32'h0);
    endtask

    task automatic t_predec;
        issue(4'd2, 2'd1, 32'h3000, 32'h0, 32'h0, 32'h0, 12'h0);
        chk("R4", "pre word ea", out_ea, 32'h2FFE);
        chk("R4", "pre word wb", out_wb_val, 32'h2FFE);
        chk("R11", "pre wb_en", {31'b0, out_wb_en}, 32'd1);
    endtask

    task automatic t_disp4;
        issue(4'd3, 2'd2, 32'h100, 32'h0, 32'h0, 32'h0, 12'h00F);
        chk("R5", "d4 long", out_ea, 32'h13C);
        issue(4'd3, 2'd0, 32'h100, 32'h0, 32'h0, 32'h0, 12'hFF3);
        chk("R5", "d4 byte upper bits ignored", out_ea, 32'h103);
        chk("R11", "d4 no wb", {31'b0, out_wb_en}, 32'd0);
    endtask

    task automatic t_index;
        issue(4'd4, 2'd0, 32'h100, 32'h24, 32'h9999, 32'h0, 12'h7);
        chk("R6", "ptr+r0", out_ea, 32'h124);
        issue(4'd6, 2'd0, 32'h1, 32'hFFFF_FFFC, 32'h8000, 32'h0, 12'h7);
        chk("R6", "gbr+r0 wrap", out_ea, 32'h7FFC);
    endtask

    task automatic t_gbr;
        issue(4'd5, 2'd1, 32'h0, 32'h0, 32'h4000, 32'h0, 12'hF80);
        chk("R7", "gbr d8 word", out_ea, 32'h4100);
        issue(4'd5, 2'd2, 32'h0, 32'h0, 32'h4000, 32'h0, 12'h0FF);
        chk("R7", "gbr d8 long max", out_ea, 32'h43FC);
    endtask

    task automatic t_pclit;
        issue(4'd7, 2'd1, 32'h0, 32'h0, 32'h0, 32'h1002, 12'h010);
        chk("R8", "pc lit word", out_ea, 32'h1022);
        issue(4'd7, 2'd2, 32'h0, 32'h0, 32'h0, 32'h1002, 12'h010);
        chk("R8", "pc lit long masked", out_ea, 32'h1040);
        chk("R10", "pc lit long aligned", {31'b0, out_misalign}, 32'd0);
    endtask

    task automatic t_branch;
        issue(4'd8, 2'd0, 32'h0, 32'h0, 32'h0, 32'h2000, 12'h0FF);
        chk("R9", "br8 minus one", out_ea, 32'h1FFE);
        chk("R9", "br flag", {31'b0, out_branch}, 32'd1);
        issue(4'd8, 2'd0, 32'h0, 32'h0, 32'h0, 32'h2000, 12'h87F);
        chk("R9", "br8 max fwd", out_ea, 32'h20FE);
        issue(4'd9, 2'd0, 32'h0, 32'h0, 32'h0, 32'h2000, 12'h800);
        chk("R9", "br12 max back", out_ea, 32'h1000);
        issue(4'd9, 2'd0, 32'h0, 32'h0, 32'h0, 32'h2000, 12'h7FF);
        chk("R9", "br12 max fwd", out_ea, 32'h2FFE);
        chk("R11", "br no wb", {31'b0, out_wb_en}, 32'd0);
    endtask

    task automatic t_misalign;
        issue(4'd0, 2'd1, 32'h101, 32'h0, 32'h0, 32'h0, 12'h0);
        chk("R10", "word odd", {31'b0, out_misalign}, 32'd1);
        issue(4'd0, 2'd2, 32'h102, 32'h0, 32'h0, 32'h0, 12'h0);
        chk("R10", "long at 2", {31'b0, out_misalign}, 32'd1);
        issue(4'd0, 2'd0, 32'h103, 32'h0, 32'h0, 32'h0, 12'h0);
        chk("R10", "byte odd ok", {31'b0, out_misalign}, 32'd0);
        issue(4'd0, 2'd1, 32'h102, 32'h0, 32'h0, 32'h0, 12'h0);
        chk("R10", "word even ok", {31'b0, out_misalign}, 32'd0);
        issue(4'd8, 2'd2, 32'h0, 32'h0, 32'h0, 32'h2001, 12'h002);
        chk("R10", "branch odd target", {31'b0, out_misalign}, 32'd1);
    endtask

    task automatic t_idle;
        issue(4'd0, 2'd0, 32'h55, 32'h0, 32'h0, 32'h0, 12'h0);
        rn_val = 32'hABCD;
        @(negedge clk);
        chk("R1", "idle vld low", {31'b0, out_vld}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ptr();
        t_postinc();
        t_predec();
        t_disp4();
        t_index();
        t_gbr();
        t_pclit();
        t_branch();
        t_misalign();
        t_idle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule